// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block takes 16-bit command writes aimed at a small set of hot-plug slots and carries them out. The low byte of a write is an operation code and the high byte picks the slot it acts on, counting from 1; bus-wide operations take no slot. While a command runs, the block shows a busy flag. When the command finishes, the block posts a coded result and sets a completion flag. That flag feeds a maskable interrupt request.

Each slot keeps three 2-bit fields: its power/enable state, a power indicator and an attention indicator. A slot operation packs new values for all three into one byte, and a zero in any subfield leaves that field as it was. Bus-wide operations set the segment speed/mode, or power or enable every slot at once. The extended speed/mode group is accepted only when the interface level parameter is 2. Software polls busy, reads the error code, and acknowledges completion by writing a clear strobe.

Top module: `hp_cmd_exec`

## Requirements
- R1: After reset every slot field reads 3 (state disabled, both indicators off), so the vector is all ones. Busy and error read 0 and the speed/mode code is 0. Both interrupt masks read 1 and the completion flag reads 0.
- R2: A write accepted while idle raises busy (`cmdStatus[0]`) on the next cycle. Busy stays high for exactly EXEC_CYCLES cycles and drops on the same edge that sets the completion flag (`ctlReg[16]`).
- R3: A command write while busy is ignored. It does not restart or lengthen the busy period and changes no slot field, speed or status.
- R4: Codes 00h–3Fh are slot operations. Code bits 1:0 give the state (1 power-only, 2 enabled, 3 disabled), bits 3:2 the power indicator and bits 5:4 the attention indicator (1 on, 2 blink, 3 off). A zero subfield leaves that field unchanged. Slot s sits in `slotFields[6s+5:6s]` as {attention, power, state}.
- R5: A slot operation whose target is 0 or greater than NUM_SLOTS ends with error 2 (invalid command) and changes nothing.
- R6: A slot operation that asks for state 1 or 2 while that slot's `latchOpen` bit is 1 ends with error 1 (switch open) and changes no field of that slot. State 3 and indicator-only operations are allowed with the latch open.
- R7: Codes 40h–44h set the speed/mode code to (code − 40h) with error 0. Codes 45h–47h end with error 2 and leave the speed unchanged.
- R8: Code 48h sets every slot's state to 1 and code 49h sets it to 2, leaving the indicators unchanged. If any `latchOpen` bit is 1, either code ends with error 1 and no slot changes.
- R9: At interface level 2, codes 50h–5Dh set the speed/mode code to (code − 50h). At level 1 they end with error 4 and leave the speed unchanged. Codes 4Ah–4Fh, 5Eh, 5Fh and 60h–FFh end with error 2.
- R10: `cmdStatus[3:1]` holds the error code: 0 success, 1 switch open, 2 invalid command, 4 unsupported speed/mode. It is cleared when a command is accepted and stays stable while busy.
- R11: A control write loads the global mask (`ctlReg[0]`) and the command mask (`ctlReg[2]`). A clear strobe resets the completion flag, but completion on the same edge wins.
- R12: `cmdPendLoc` is the completion flag AND NOT the command mask. `irqReq` is `cmdPendLoc` AND NOT the global mask.
- R13: At interface level 1 the speed/mode code is 3 bits wide and never exceeds 4. At level 2 it is 4 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWord | input | 16 | {target slot, operation code} |
| latchOpen | input | NUM_SLOTS | Per-slot latch sensor, 1 = open |
| ctlWrEn | input | 1 | Control write strobe |
| ctlGlobalMask | input | 1 | Global interrupt mask value to load |
| ctlCmdMask | input | 1 | Command interrupt mask value to load |
| ctlClearDone | input | 1 | Clear the completion flag (with ctlWrEn) |
| cmdStatus | output | 4 | {error code, busy} |
| slotFields | output | 6*NUM_SLOTS | Per-slot {attention, power, state} |
| busSpeed | output | 4 | Current speed/mode code |
| ctlReg | output | 32 | Bit 16 done flag, bit 2 command mask, bit 0 global mask |
| cmdPendLoc | output | 1 | Pending completion after the command mask |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench builds two copies with NUM_SLOTS=3 and EXEC_CYCLES=5. One runs at interface level 2 and the other at level 1, and both get the same stimulus. Three slots make target 4 a reachable out-of-range value. Five execution cycles leave room to inject a second write and a clear strobe inside a busy window. The level-1 copy exposes the speed/mode rejection and the narrower speed code.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef struct packed {
    logic accept;
    logic finish;
  } hpxStrobe_t;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_LATCH = 3'd1;
  localparam logic [2:0] ERR_BAD   = 3'd2;
  localparam logic [2:0] ERR_SPEED = 3'd4;

  localparam int         FLD_W    = 6;
  localparam logic [5:0] SLOT_RST = 6'h3F;
endpackage

// File: rtl/hpx_decode.sv
module hpx_decode #(
  parameter int NUM_SLOTS = 4,
  parameter int PI_LEVEL  = 2,
  parameter int SPD_W     = 4
) (
  input  logic [15:0]          cmdWord,
  input  logic [NUM_SLOTS-1:0] latchOpen,
  output logic [2:0]           errCode,
  output logic [NUM_SLOTS-1:0] slotHit,
  output logic [2:0]           fieldWe,
  output logic [5:0]           fieldVal,
  output logic                 speedWe,
  output logic [SPD_W-1:0]     speedVal
);
  import hpx_pkg::*;

  localparam bit EXT_OK = (PI_LEVEL >= 2);

  logic [7:0]           code;
  logic [7:0]           tgt;
  logic [NUM_SLOTS-1:0] tgtHit;
  logic                 wantPower;

  assign code      = cmdWord[7:0];
  assign tgt       = cmdWord[15:8];
  assign wantPower = (code[1:0] == 2'd1) || (code[1:0] == 2'd2);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) tgtHit[i] = (tgt == 8'(i + 1));
  end

  always_comb begin
    errCode  = ERR_NONE;
    slotHit  = '0;
    fieldWe  = 3'b000;
    fieldVal = 6'd0;
    speedWe  = 1'b0;
    speedVal = '0;
    if (code[7:6] == 2'b00) begin
      if (tgtHit == '0) errCode = ERR_BAD;
      else if (wantPower && ((tgtHit & latchOpen) != '0)) errCode = ERR_LATCH;
      else begin
        slotHit  = tgtHit;
        fieldWe  = {code[5:4] != 2'd0, code[3:2] != 2'd0, code[1:0] != 2'd0};
        fieldVal = code[5:0];
      end
    end else if (code >= 8'h40 && code <= 8'h44) begin
      speedWe  = 1'b1;
      speedVal = SPD_W'(code - 8'h40);
    end else if (code == 8'h48 || code == 8'h49) begin
      if (latchOpen != '0) errCode = ERR_LATCH;
      else begin
        slotHit  = '1;
        fieldWe  = 3'b001;
        fieldVal = (code == 8'h49) ? 6'd2 : 6'd1;
      end
    end else if (code >= 8'h50 && code <= 8'h5D) begin
      if (EXT_OK) begin
        speedWe  = 1'b1;
        speedVal = SPD_W'(code[3:0]);
      end else errCode = ERR_SPEED;
    end else begin
      errCode = ERR_BAD;
    end
  end
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl #(
  parameter int EXEC_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  output logic               busy,
  output hpx_pkg::hpxStrobe_t strobe
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign strobe.accept = cmdWrEn && !busy;
  assign strobe.finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strobe.accept) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(EXEC_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hpx_datapath.sv
module hpx_datapath #(
  parameter int NUM_SLOTS = 4,
  parameter int PI_LEVEL  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hpx_pkg::hpxStrobe_t      strobe,
  input  logic [15:0]              cmdWord,
  input  logic [NUM_SLOTS-1:0]     latchOpen,
  input  logic                     ctlWrEn,
  input  logic                     ctlGlobalMask,
  input  logic                     ctlCmdMask,
  input  logic                     ctlClearDone,
  output logic [2:0]               errCode,
  output logic [6*NUM_SLOTS-1:0]   slotFields,
  output logic [3:0]               busSpeed,
  output logic                     doneFlag,
  output logic                     globalMask,
  output logic                     cmdMask
);
  import hpx_pkg::*;

  localparam int SPD_W = (PI_LEVEL >= 2) ? 4 : 3;

  logic [15:0]          cmdHeld;
  logic [2:0]           decErr;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [2:0]           fieldWe;
  logic [5:0]           fieldVal;
  logic                 speedWe;
  logic [SPD_W-1:0]     speedVal;
  logic [SPD_W-1:0]     speedReg;

  hpx_decode #(.NUM_SLOTS(NUM_SLOTS), .PI_LEVEL(PI_LEVEL), .SPD_W(SPD_W)) u_dec (
    .cmdWord(cmdHeld), .latchOpen(latchOpen), .errCode(decErr),
    .slotHit(slotHit), .fieldWe(fieldWe), .fieldVal(fieldVal),
    .speedWe(speedWe), .speedVal(speedVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdHeld  <= 16'd0;
      errCode  <= ERR_NONE;
      speedReg <= '0;
    end else begin
      if (strobe.accept) begin
        cmdHeld <= cmdWord;
        errCode <= ERR_NONE;
      end
      if (strobe.finish) begin
        errCode <= decErr;
        if (speedWe) speedReg <= speedVal;
      end
    end
  end

  assign busSpeed = 4'(speedReg);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [FLD_W-1:0] fld;
    always_ff @(posedge clk) begin
      if (!rstN) fld <= SLOT_RST;
      else if (strobe.finish && slotHit[s]) begin
        if (fieldWe[0]) fld[1:0] <= fieldVal[1:0];
        if (fieldWe[1]) fld[3:2] <= fieldVal[3:2];
        if (fieldWe[2]) fld[5:4] <= fieldVal[5:4];
      end
    end
    assign slotFields[s*FLD_W +: FLD_W] = fld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      globalMask <= 1'b1;
      cmdMask    <= 1'b1;
    end else begin
      if (ctlWrEn) begin
        globalMask <= ctlGlobalMask;
        cmdMask    <= ctlCmdMask;
      end
      if (strobe.finish) doneFlag <= 1'b1;
      else if (ctlWrEn && ctlClearDone) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/hp_cmd_exec.sv
module hp_cmd_exec #(
  parameter int NUM_SLOTS   = 4,
  parameter int EXEC_CYCLES = 4,
  parameter int PI_LEVEL    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdWrEn,
  input  logic [15:0]            cmdWord,
  input  logic [NUM_SLOTS-1:0]   latchOpen,
  input  logic                   ctlWrEn,
  input  logic                   ctlGlobalMask,
  input  logic                   ctlCmdMask,
  input  logic                   ctlClearDone,
  output logic [3:0]             cmdStatus,
  output logic [6*NUM_SLOTS-1:0] slotFields,
  output logic [3:0]             busSpeed,
  output logic [31:0]            ctlReg,
  output logic                   cmdPendLoc,
  output logic                   irqReq
);
  hpx_pkg::hpxStrobe_t strobe;
  logic       busy;
  logic [2:0] errCode;
  logic       doneFlag;
  logic       globalMask;
  logic       cmdMask;

  hpx_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .busy(busy), .strobe(strobe)
  );

  hpx_datapath #(.NUM_SLOTS(NUM_SLOTS), .PI_LEVEL(PI_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWord(cmdWord),
    .latchOpen(latchOpen), .ctlWrEn(ctlWrEn), .ctlGlobalMask(ctlGlobalMask),
    .ctlCmdMask(ctlCmdMask), .ctlClearDone(ctlClearDone), .errCode(errCode),
    .slotFields(slotFields), .busSpeed(busSpeed), .doneFlag(doneFlag),
    .globalMask(globalMask), .cmdMask(cmdMask)
  );

  assign cmdStatus  = {errCode, busy};
  assign ctlReg     = {15'd0, doneFlag, 13'd0, cmdMask, 1'b0, globalMask};
  assign cmdPendLoc = doneFlag && !cmdMask;
  assign irqReq     = cmdPendLoc && !globalMask;
endmodule

// File: rtl/hp_cmd_exec_chk.sv
module hp_cmd_exec_chk #(
  parameter int NUM_SLOTS   = 4,
  parameter int EXEC_CYCLES = 4,
  parameter int PI_LEVEL    = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdWrEn,
  input logic [3:0]             cmdStatus,
  input logic [6*NUM_SLOTS-1:0] slotFields,
  input logic [3:0]             busSpeed,
  input logic [31:0]            ctlReg,
  input logic                   cmdPendLoc,
  input logic                   irqReq
);
  logic [15:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 16'd0;
    else if (cmdStatus[0]) busyRun <= busyRun + 16'd1;
    else busyRun <= 16'd0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !cmdStatus[0]) |=> cmdStatus[0]);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdStatus[0]) |-> (busyRun == 16'(EXEC_CYCLES)));

  p_done_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdStatus[0]) |-> ctlReg[16]);

  p_err_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStatus[0] && $past(cmdStatus[0])) |-> $stable(cmdStatus[3:1]));

  p_err_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStatus[3:1]));

  p_slots_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(cmdStatus[0]) |-> $stable(slotFields));

  p_loc_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdPendLoc |-> (ctlReg[16] && !ctlReg[2]));

  p_irq_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (cmdPendLoc && !ctlReg[0]));

  p_speed_lvl1_r13: assert property (@(posedge clk) disable iff (!rstN)
    (PI_LEVEL < 2) |-> (busSpeed <= 4'd4));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_fld
    p_field_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
      (slotFields[6*s +: 2] != 2'd0) && (slotFields[6*s+2 +: 2] != 2'd0) &&
      (slotFields[6*s+4 +: 2] != 2'd0));
  end
endmodule

bind hp_cmd_exec hp_cmd_exec_chk #(
  .NUM_SLOTS(NUM_SLOTS), .EXEC_CYCLES(EXEC_CYCLES), .PI_LEVEL(PI_LEVEL)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdStatus(cmdStatus),
  .slotFields(slotFields), .busSpeed(busSpeed), .ctlReg(ctlReg),
  .cmdPendLoc(cmdPendLoc), .irqReq(irqReq)
);

// File: tb/sim_hp_cmd_exec.sv
module sim_hp_cmd_exec;
  localparam int NS = 3;
  localparam int EX = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWrEn = 1'b0;
  logic [15:0]   cmdWord = 16'd0;
  logic [NS-1:0] latchOpen = '0;
  logic          ctlWrEn = 1'b0;
  logic          ctlGlobalMask = 1'b0;
  logic          ctlCmdMask = 1'b0;
  logic          ctlClearDone = 1'b0;

  logic [3:0]    st0, st1;
  logic [6*NS-1:0] fld0, fld1;
  logic [3:0]    spd0, spd1;
  logic [31:0]   ctl0, ctl1;
  logic          loc0, loc1, irq0, irq1;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  hp_cmd_exec #(.NUM_SLOTS(NS), .EXEC_CYCLES(EX), .PI_LEVEL(2)) u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .latchOpen(latchOpen), .ctlWrEn(ctlWrEn), .ctlGlobalMask(ctlGlobalMask),
    .ctlCmdMask(ctlCmdMask), .ctlClearDone(ctlClearDone), .cmdStatus(st0),
    .slotFields(fld0), .busSpeed(spd0), .ctlReg(ctl0), .cmdPendLoc(loc0),
    .irqReq(irq0)
  );

  hp_cmd_exec #(.NUM_SLOTS(NS), .EXEC_CYCLES(EX), .PI_LEVEL(1)) u1 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .latchOpen(latchOpen), .ctlWrEn(ctlWrEn), .ctlGlobalMask(ctlGlobalMask),
    .ctlCmdMask(ctlCmdMask), .ctlClearDone(ctlClearDone), .cmdStatus(st1),
    .slotFields(fld1), .busSpeed(spd1), .ctlReg(ctl1), .cmdPendLoc(loc1),
    .irqReq(irq1)
  );

  // {req, cmd, latch, err, speed, {slot2, slot1, slot0}}
  localparam int NV = 17;
  localparam logic [47:0] VEC [NV] = '{
    {4'd4, 16'h0101, 3'b000, 3'd0, 4'd0, 6'h3F, 6'h3F, 6'h3D}, // R4 power-only slot 1
    {4'd4, 16'h0122, 3'b000, 3'd0, 4'd0, 6'h3F, 6'h3F, 6'h2E}, // R4 enable, attention blink, power kept
    {4'd6, 16'h020A, 3'b010, 3'd1, 4'd0, 6'h3F, 6'h3F, 6'h2E}, // R6 enable with latch open
    {4'd4, 16'h0234, 3'b010, 3'd0, 4'd0, 6'h3F, 6'h37, 6'h2E}, // R4 indicators only, latch open
    {4'd6, 16'h0303, 3'b100, 3'd0, 4'd0, 6'h3F, 6'h37, 6'h2E}, // R6 disable allowed with latch open
    {4'd5, 16'h0401, 3'b000, 3'd2, 4'd0, 6'h3F, 6'h37, 6'h2E}, // R5 target above slot count
    {4'd5, 16'h0001, 3'b000, 3'd2, 4'd0, 6'h3F, 6'h37, 6'h2E}, // R5 target zero
    {4'd7, 16'h0043, 3'b000, 3'd0, 4'd3, 6'h3F, 6'h37, 6'h2E}, // R7 base speed
    {4'd7, 16'h0046, 3'b000, 3'd2, 4'd3, 6'h3F, 6'h37, 6'h2E}, // R7 reserved speed code
    {4'd9, 16'h0057, 3'b000, 3'd0, 4'd7, 6'h3F, 6'h37, 6'h2E}, // R9 extended speed
    {4'd8, 16'h0048, 3'b001, 3'd1, 4'd7, 6'h3F, 6'h37, 6'h2E}, // R8 all-slot with one latch open
    {4'd8, 16'h0048, 3'b000, 3'd0, 4'd7, 6'h3D, 6'h35, 6'h2D}, // R8 power-only all
    {4'd8, 16'h0049, 3'b000, 3'd0, 4'd7, 6'h3E, 6'h36, 6'h2E}, // R8 enable all
    {4'd9, 16'h004C, 3'b000, 3'd2, 4'd7, 6'h3E, 6'h36, 6'h2E}, // R9 reserved bus-wide
    {4'd9, 16'h0080, 3'b000, 3'd2, 4'd7, 6'h3E, 6'h36, 6'h2E}, // R9 high reserved
    {4'd9, 16'h005E, 3'b000, 3'd2, 4'd7, 6'h3E, 6'h36, 6'h2E}, // R9 reserved extended
    {4'd4, 16'h0300, 3'b000, 3'd0, 4'd7, 6'h3E, 6'h36, 6'h2E}  // R4 all subfields zero
  };

  task automatic chk(input int req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Issue a command and wait for completion; R2 timing and R10 clear-on-accept.
  task automatic issue(input logic [15:0] word, input logic [NS-1:0] latch);
    @(negedge clk);
    cmdWord = word; latchOpen = latch; cmdWrEn = 1'b1;
    @(posedge clk); #1;
    cmdWrEn = 1'b0;
    chk(2, "busy after accept", 32'(st0[0]), 32'd1);
    chk(10, "error cleared on accept", 32'(st0[3:1]), 32'd0);
    repeat (EX - 1) @(posedge clk);
    #1 chk(2, "busy in last cycle", 32'(st0[0]), 32'd1);
    @(posedge clk); #1;
    chk(2, "busy dropped", 32'(st0[0]), 32'd0);
    chk(2, "done flag with busy fall", 32'(ctl0[16]), 32'd1);
  endtask

  task automatic ctlWrite(input logic gm, input logic cm, input logic clr);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlGlobalMask = gm; ctlCmdMask = cm; ctlClearDone = clr;
    @(posedge clk); #1;
    ctlWrEn = 1'b0; ctlClearDone = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL R2 watchdog got=%0d exp=%0d", 50000, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(1, "status", 32'(st0), 32'd0);
    chk(1, "fields", 32'(fld0), 32'h3FFFF);
    chk(1, "speed", 32'(spd0), 32'd0);
    chk(1, "ctl masks", ctl0, 32'h0000_0005);
    chk(1, "irq", 32'({loc0, irq0}), 32'd0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][43:28], VEC[v][27:25]);
      chk(int'(VEC[v][47:44]), $sformatf("vec %0d error", v), 32'(st0[3:1]), 32'(VEC[v][24:22]));
      chk(int'(VEC[v][47:44]), $sformatf("vec %0d speed", v), 32'(spd0), 32'(VEC[v][21:18]));
      chk(int'(VEC[v][47:44]), $sformatf("vec %0d fields", v), 32'(fld0), 32'(VEC[v][17:0]));
    end

    // R9 and R13: level-1 copy rejects extended speed, keeps 3-bit code
    issue(16'h0057, 3'b000);
    chk(9, "lvl1 extended error", 32'(st1[3:1]), 32'd4);
    chk(13, "lvl1 speed kept", 32'(spd1), 32'd3);
    chk(9, "lvl2 extended ok", 32'(spd0), 32'd7);
    issue(16'h0044, 3'b000);
    chk(13, "lvl1 speed 4", 32'(spd1), 32'd4);
    chk(7, "lvl2 speed 4", 32'(spd0), 32'd4);

    // R3: write during busy is ignored
    @(negedge clk);
    cmdWord = 16'h0131; latchOpen = '0; cmdWrEn = 1'b1;
    @(posedge clk); #1 cmdWrEn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); cmdWord = 16'h0210; cmdWrEn = 1'b1;
    @(posedge clk); #1 cmdWrEn = 1'b0;
    repeat (EX - 3) @(posedge clk);
    #1 chk(3, "busy length unchanged", 32'(st0[0]), 32'd0);
    chk(3, "only first command applied", 32'(fld0), {14'd0, 6'h3E, 6'h36, 6'h3D});
    repeat (EX + 2) @(posedge clk);
    #1 chk(3, "no late start", 32'(st0[0]), 32'd0);
    chk(3, "fields after idle", 32'(fld0), {14'd0, 6'h3E, 6'h36, 6'h3D});

    // R11 and R12: masks, locator, interrupt, clear
    chk(12, "masked loc/irq", 32'({loc0, irq0}), 32'd0);
    ctlWrite(1'b0, 1'b0, 1'b0);
    chk(11, "ctl after unmask", ctl0, 32'h0001_0000);
    chk(12, "loc/irq unmasked", 32'({loc0, irq0}), 32'd3);
    ctlWrite(1'b1, 1'b0, 1'b0);
    chk(12, "global mask blocks irq", 32'({loc0, irq0}), 32'd2);
    ctlWrite(1'b1, 1'b0, 1'b1);
    chk(11, "clear done", ctl0, 32'h0000_0001);
    chk(12, "loc after clear", 32'(loc0), 32'd0);

    // R11: completion wins over a clear on the same edge
    @(negedge clk);
    cmdWord = 16'h0300; cmdWrEn = 1'b1;
    @(posedge clk); #1 cmdWrEn = 1'b0;
    repeat (EX - 1) @(posedge clk);
    #1 ctlWrEn = 1'b1; ctlGlobalMask = 1'b1; ctlCmdMask = 1'b0; ctlClearDone = 1'b1;
    @(posedge clk); #1;
    ctlWrEn = 1'b0; ctlClearDone = 1'b0;
    chk(11, "set wins over clear", 32'(ctl0[16]), 32'd1);
    chk(2, "busy fell with set", 32'(st0[0]), 32'd0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule